// File: doc/BRIEF.md
# Iterative Shift and Rotate Unit

This block carries out the eight shift and rotate operations of a small processor datapath: logical left shift, arithmetic left shift, logical right shift, arithmetic right shift, the two plain rotates and the two rotates that pass through the carry flag. It works on either a byte or a 16-bit word. Instead of using a barrel shifter, it moves the operand by one bit on each clock until the requested count is used up. The carry flag is carried from each one-bit step into the next, so a count of N gives the same result as N separate one-bit operations.

The caller pulses `start` for one cycle. With that pulse it presents the operation code, the width select, the operand, the incoming carry and overflow flags, and two count sources: an immediate value and the value of the count register. A select input chooses which of the two counts applies. The unit raises `busy` while it steps. After the last step it pulses `done` for one cycle. The result and the final flags stay on the outputs until the next operation is accepted.

Top module: `shift_rotate_unit`

## Requirements
- R1: After a synchronous active-low reset, `result`, `cf_out`, `of_out`, `busy` and `done` are all 0.
- R2: Operation codes are SHL=0, SAL=1, SHR=2, SAR=3, ROL=4, ROR=5, RCL=6, RCR=7. SHL and SAL behave identically: a one-bit byte shift of E0h gives C0h with CF=1.
- R3: SHR fills the vacated top bit with 0, so 07h by one gives 03h with CF=1. SAR copies the sign bit, so E0h gives F0h and 4Ch gives 26h, both with CF=0. In all shifts and rotates CF receives the bit that leaves the operand.
- R4: ROL and ROR move the bit that leaves one end into the other end. For 1Ch, ROL gives 38h and ROR gives 0Eh, both with CF=0.
- R5: RCL and RCR rotate through CF as an extra bit. With CF=1 at the start, RCL of 1Ch gives 39h and RCR of 1Ch gives 8Eh, both with CF=0.
- R6: The count is taken from `imm_count` when `count_src`=0 and from `cl_value` when `count_src`=1. Only its low 5 bits are used. A count N gives the same result as N one-bit steps in sequence, with CF passed from each step to the next.
- R7: A count of 0 brings `done` in the first cycle after the start is accepted. The operand is returned unchanged, and `cf_out`/`of_out` equal `cf_in`/`of_in`.
- R8: OF comes from the last step. For SHL, SAL, ROL and RCL it is the result's top bit XOR CF. For SHR it is the operand's top bit before that step. For SAR it is 0. For ROR and RCR it is the XOR of the result's two top bits.
- R9: For a count N of 1 or more, `busy` is high for N cycles. `done` is high for exactly one cycle, N+1 cycles after the accepting edge's cycle, and `busy` is low while `done` is high.
- R10: A `start` pulse while `busy` is high is ignored. The running operation finishes with its own result and timing.
- R11: When `wide`=0 (byte mode) the unit uses only `operand[7:0]`, and `result[15:8]` is 0. When `wide`=1 (word mode) all 16 bits are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op | input | 3 | Operation code |
| wide | input | 1 | 1 selects word mode, 0 selects byte mode |
| count_src | input | 1 | 0 selects the immediate count, 1 selects the count register |
| imm_count | input | 8 | Immediate count |
| cl_value | input | 8 | Count register value |
| operand | input | 16 | Value to shift |
| cf_in | input | 1 | Incoming carry flag |
| of_in | input | 1 | Incoming overflow flag |
| busy | output | 1 | Steps in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Shifted value |
| cf_out | output | 1 | Final carry flag |
| of_out | output | 1 | Final overflow flag |

## Verification
First, the single-step byte examples are checked against fixed values. These tell apart fill with zero, fill with sign, wrap-around, and insertion of CF. Next, every operation is swept over counts 0 to 31 in both widths. This uses two operands with different top bits, with CF both set and clear, and compares against an independent step-by-step model. The sweep exposes any CF that is not passed between steps, any wrong step count, and any leak into the upper byte. Separate cases cover a count taken from the count register rather than the immediate, a count above 31 that must be masked, and a start pulse during a busy operation, which must leave both the result and the latency unchanged.

// File: rtl/sru_pkg.sv
// Package: shared types for the iterative shift and rotate unit.
// Assumes: operation codes are fixed by the instruction decoder upstream.
package sru_pkg;

    typedef enum logic [2:0] {
        OP_SHL = 3'd0,
        OP_SAL = 3'd1,
        OP_SHR = 3'd2,
        OP_SAR = 3'd3,
        OP_ROL = 3'd4,
        OP_ROR = 3'd5,
        OP_RCL = 3'd6,
        OP_RCR = 3'd7
    } sru_op_e;

endpackage

// File: rtl/sru_count_sel.sv
// Module: sru_count_sel
// Picks the shift count from the immediate or the count register and keeps
// only its low CNT_W bits.
// Assumes: SRC_W >= CNT_W.
module sru_count_sel #(
    parameter int SRC_W = 8,
    parameter int CNT_W = 5
) (
    input  logic             use_reg,
    input  logic [SRC_W-1:0] imm_val,
    input  logic [SRC_W-1:0] reg_val,
    output logic [CNT_W-1:0] count
);

    logic [SRC_W-1:0] chosen;

    // Select the count source, then truncate it to the used field.
    always_comb begin
        chosen = use_reg ? reg_val : imm_val;
        count  = chosen[CNT_W-1:0];
    end

endmodule

// File: rtl/sru_step.sv
// Module: sru_step
// Combinational one-bit shift or rotate of a W-bit lane, giving the new
// value, the carry that leaves the lane, and the overflow for this step.
// Assumes: W >= 2; the caller holds the lane's upper context at zero.
module sru_step
    import sru_pkg::*;
#(
    parameter int W = 8
) (
    input  sru_op_e      op,
    input  logic [W-1:0] d,
    input  logic         cf_i,
    output logic [W-1:0] q,
    output logic         cf_o,
    output logic         of_o
);

    // One step of the selected operation, with its flag rules.
    always_comb begin
        q    = d;
        cf_o = cf_i;
        of_o = 1'b0;
        unique case (op)
            OP_SHL, OP_SAL: begin
                q    = {d[W-2:0], 1'b0};
                cf_o = d[W-1];
                of_o = d[W-2] ^ d[W-1];
            end
            OP_SHR: begin
                q    = {1'b0, d[W-1:1]};
                cf_o = d[0];
                of_o = d[W-1];
            end
            OP_SAR: begin
                q    = {d[W-1], d[W-1:1]};
                cf_o = d[0];
                of_o = 1'b0;
            end
            OP_ROL: begin
                q    = {d[W-2:0], d[W-1]};
                cf_o = d[W-1];
                of_o = d[W-2] ^ d[W-1];
            end
            OP_ROR: begin
                q    = {d[0], d[W-1:1]};
                cf_o = d[0];
                of_o = d[0] ^ d[W-1];
            end
            OP_RCL: begin
                q    = {d[W-2:0], cf_i};
                cf_o = d[W-1];
                of_o = d[W-2] ^ d[W-1];
            end
            OP_RCR: begin
                q    = {cf_i, d[W-1:1]};
                cf_o = d[0];
                of_o = cf_i ^ d[W-1];
            end
            default: begin
                q    = d;
                cf_o = cf_i;
                of_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sru_ctrl.sv
// Module: sru_ctrl
// Step sequencer: accepts a start when idle, counts down the steps, and
// pulses done once after the last step (or right away for a zero count).
// Assumes: start is a level sampled on each rising edge.
module sru_ctrl #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    output logic             accept,
    output logic             step_en,
    output logic             busy,
    output logic             done
);

    logic             busy_q;
    logic             done_q;
    logic [CNT_W-1:0] left_q;

    // A start is taken only while no operation is running.
    always_comb begin
        accept  = start && !busy_q;
        step_en = busy_q;
        busy    = busy_q;
        done    = done_q;
    end

    // Load the count, run it down one per cycle, and pulse done at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            left_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                if (count == '0) begin
                    done_q <= 1'b1;
                end else begin
                    busy_q <= 1'b1;
                    left_q <= count;
                end
            end else if (busy_q) begin
                left_q <= left_q - 1'b1;
                if (left_q == {{(CNT_W-1){1'b0}}, 1'b1}) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    // R9
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);

    // R10
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && left_q > {{(CNT_W-1){1'b0}}, 1'b1}) |=> (busy_q && !done_q));

endmodule

// File: rtl/shift_rotate_unit.sv
// Module: shift_rotate_unit (top)
// Iterative byte/word shifter and rotator. Each busy cycle applies one
// single-bit step. CF is passed between steps, and OF is taken from the last step.
// Assumes: a new operation is issued only after done, or its start is dropped.
module shift_rotate_unit
    import sru_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8,
    parameter int SRC_W    = 8,
    parameter int CNT_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic              wide,
    input  logic              count_src,
    input  logic [SRC_W-1:0]  imm_count,
    input  logic [SRC_W-1:0]  cl_value,
    input  logic [DATA_W-1:0] operand,
    input  logic              cf_in,
    input  logic              of_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              cf_out,
    output logic              of_out
);

    localparam int UPPER_W = DATA_W - NARROW_W;
    localparam int NLANES  = 2;

    logic [CNT_W-1:0]  count_w;
    logic              accept;
    logic              step_en;
    logic [DATA_W-1:0] data_q;
    logic              cf_q;
    logic              of_q;
    sru_op_e           op_q;
    logic              wide_q;

    logic [DATA_W-1:0] lane_q  [NLANES];
    logic              lane_cf [NLANES];
    logic              lane_of [NLANES];

    sru_count_sel #(.SRC_W(SRC_W), .CNT_W(CNT_W)) u_cnt (
        .use_reg (count_src),
        .imm_val (imm_count),
        .reg_val (cl_value),
        .count   (count_w)
    );

    sru_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .count   (count_w),
        .accept  (accept),
        .step_en (step_en),
        .busy    (busy),
        .done    (done)
    );

    // Lane 0 steps the byte view, lane 1 the full word view.
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        localparam int LW = (g == 0) ? NARROW_W : DATA_W;
        logic [LW-1:0] q_w;
        logic          cf_w;
        logic          of_w;

        sru_step #(.W(LW)) u_step (
            .op   (op_q),
            .d    (data_q[LW-1:0]),
            .cf_i (cf_q),
            .q    (q_w),
            .cf_o (cf_w),
            .of_o (of_w)
        );

        // Zero-extend the lane result to the full data width.
        always_comb begin
            lane_q[g]        = '0;
            lane_q[g][LW-1:0] = q_w;
            lane_cf[g]       = cf_w;
            lane_of[g]       = of_w;
        end
    end

    // Capture the operation on accept, then apply one lane step per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            cf_q   <= 1'b0;
            of_q   <= 1'b0;
            op_q   <= OP_SHL;
            wide_q <= 1'b0;
        end else if (accept) begin
            data_q <= wide ? operand : {{UPPER_W{1'b0}}, operand[NARROW_W-1:0]};
            cf_q   <= cf_in;
            of_q   <= of_in;
            op_q   <= sru_op_e'(op);
            wide_q <= wide;
        end else if (step_en) begin
            data_q <= lane_q[wide_q];
            cf_q   <= lane_cf[wide_q];
            of_q   <= lane_of[wide_q];
        end
    end

    // Drive the held state straight onto the result ports.
    always_comb begin
        result = data_q;
        cf_out = cf_q;
        of_out = of_q;
    end

    // R7
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && count_w == '0) |=>
            (done && cf_out == $past(cf_in) && of_out == $past(of_in)));

    // R11
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_q |-> (result[DATA_W-1:NARROW_W] == '0));

    // R8
    sar_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_SAR && $past(busy)) |-> !of_out);

    // R10
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(op_q) && $stable(wide_q));

endmodule

// File: tb/tb_shift_rotate_unit.sv
module tb_shift_rotate_unit;
    import sru_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic        wide = 1'b0;
    logic        count_src = 1'b0;
    logic [7:0]  imm_count = 8'd0;
    logic [7:0]  cl_value = 8'd0;
    logic [15:0] operand = 16'd0;
    logic        cf_in = 1'b0;
    logic        of_in = 1'b0;
    logic        busy;
    logic        done;
    logic [15:0] result;
    logic        cf_out;
    logic        of_out;

    int checks = 0;
    int fails  = 0;

    shift_rotate_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
        .count_src(count_src), .imm_count(imm_count), .cl_value(cl_value),
        .operand(operand), .cf_in(cf_in), .of_in(of_in), .busy(busy),
        .done(done), .result(result), .cf_out(cf_out), .of_out(of_out)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Independent reference: repeated one-bit steps, from the requirements.
    function automatic logic [17:0] model(input int o, input bit w, input logic [15:0] d,
                                          input bit c, input bit v, input int n);
        int   msb = w ? 15 : 7;
        logic [15:0] x = w ? d : {8'h00, d[7:0]};
        logic [15:0] y;
        for (int s = 0; s < n; s++) begin
            y = x;
            case (o)
                0, 1: begin y = (x << 1) & (w ? 16'hFFFF : 16'h00FF); c = x[msb]; v = y[msb] ^ c; end
                2: begin y = x >> 1; c = x[0]; v = x[msb]; end
                3: begin y = x >> 1; y[msb] = x[msb]; c = x[0]; v = 1'b0; end
                4: begin y = (x << 1) & (w ? 16'hFFFF : 16'h00FF); y[0] = x[msb]; c = x[msb]; v = y[msb] ^ c; end
                5: begin y = x >> 1; y[msb] = x[0]; c = x[0]; v = y[msb] ^ y[msb-1]; end
                6: begin y = (x << 1) & (w ? 16'hFFFF : 16'h00FF); y[0] = c; c = x[msb]; v = y[msb] ^ c; end
                default: begin y = x >> 1; y[msb] = c; c = x[0]; v = y[msb] ^ y[msb-1]; end
            endcase
            x = y;
        end
        return {c, v, x};
    endfunction

    // Issue one operation and return its latency in cycles (0 = timed out).
    task automatic issue(input int o, input bit w, input bit src, input logic [7:0] ic,
                         input logic [7:0] cl, input logic [15:0] d, input bit c,
                         input bit v, output int lat);
        @(negedge clk);
        op = 3'(o); wide = w; count_src = src; imm_count = ic; cl_value = cl;
        operand = d; cf_in = c; of_in = v; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        for (int k = 1; k <= 80; k++) begin
            if (done) begin lat = k; break; end
            @(negedge clk);
        end
    endtask

    // Full check of one run against the model, latency and the done pulse.
    task automatic run_case(input string req, input int o, input bit w, input bit src,
                            input logic [7:0] ic, input logic [7:0] cl,
                            input logic [15:0] d, input bit c, input bit v);
        int lat;
        int n = src ? int'(cl[4:0]) : int'(ic[4:0]);
        logic [17:0] e = model(o, w, d, c, v, n);
        issue(o, w, src, ic, cl, d, c, v, lat);
        chk(lat == n + 1, {req, " latency R9"}, lat, n + 1);
        chk(result == e[15:0], {req, " result"}, result, e[15:0]);
        chk(cf_out == e[17], {req, " cf"}, cf_out, e[17]);
        chk(of_out == e[16], {req, " of R8"}, of_out, e[16]);
        chk(!busy, "R9 busy low at done", busy, 0);
        @(negedge clk);
        chk(!done, "R9 done one cycle", done, 0);
    endtask

    task automatic t_reset;
        chk(result == 16'h0 && !cf_out && !of_out, "R1 reset outputs", {result, cf_out, of_out}, 0);
        chk(!busy && !done, "R1 reset busy/done", {busy, done}, 0);
    endtask

    // Fixed single-step byte examples.
    task automatic fact(input string req, input int o, input logic [7:0] d, input bit c,
                        input logic [7:0] er, input bit ecf);
        int lat;
        issue(o, 1'b0, 1'b0, 8'd1, 8'd0, {8'hFF, d}, c, 1'b0, lat);
        chk(result == {8'h00, er}, req, result, {8'h00, er});
        chk(cf_out == ecf, {req, " cf"}, cf_out, ecf);
        @(negedge clk);
    endtask

    task automatic t_facts;
        fact("R2 SHL E0", 0, 8'hE0, 1'b0, 8'hC0, 1'b1);
        fact("R2 SAL E0", 1, 8'hE0, 1'b0, 8'hC0, 1'b1);
        fact("R3 SHR 07", 2, 8'h07, 1'b0, 8'h03, 1'b1);
        fact("R3 SAR E0", 3, 8'hE0, 1'b1, 8'hF0, 1'b0);
        fact("R3 SAR 4C", 3, 8'h4C, 1'b1, 8'h26, 1'b0);
        fact("R4 ROL 1C", 4, 8'h1C, 1'b1, 8'h38, 1'b0);
        fact("R4 ROR 1C", 5, 8'h1C, 1'b1, 8'h0E, 1'b0);
        fact("R5 RCL 1C", 6, 8'h1C, 1'b1, 8'h39, 1'b0);
        fact("R5 RCR 1C", 7, 8'h1C, 1'b1, 8'h8E, 1'b0);
    endtask

    task automatic t_zero_count;
        run_case("R7 zero count word", 5, 1'b1, 1'b0, 8'd0, 8'd7, 16'hBEEF, 1'b1, 1'b1);
        run_case("R7 zero count byte R11", 6, 1'b0, 1'b0, 8'd0, 8'd7, 16'h1234, 1'b0, 1'b1);
        chk(result == 16'h0034, "R11 upper byte ignored", result, 16'h0034);
    endtask

    task automatic t_count_src;
        run_case("R6 count from register", 4, 1'b1, 1'b1, 8'd9, 8'd3, 16'h8001, 1'b0, 1'b0);
        run_case("R6 count masked to 5 bits", 6, 1'b1, 1'b0, 8'd37, 8'd0, 16'hC35A, 1'b1, 1'b0);
    endtask

    task automatic t_sweep;
        for (int o = 0; o < 8; o++)
            for (int w = 0; w < 2; w++)
                for (int n = 0; n < 32; n++)
                    for (int p = 0; p < 2; p++)
                        run_case("R6 sweep", o, w[0], 1'b0, 8'(n), 8'd0,
                                 p ? 16'h813E : 16'h6AC3, p[0] ^ n[0], 1'b0);
    endtask

    task automatic t_ignore_start;
        int lat;
        logic [17:0] e = model(4, 1'b1, 16'h00F1, 1'b0, 1'b0, 10);
        @(negedge clk);
        op = 3'd4; wide = 1'b1; count_src = 1'b0; imm_count = 8'd10;
        operand = 16'h00F1; cf_in = 1'b0; of_in = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        op = 3'd2; operand = 16'hFFFF; imm_count = 8'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 4;
        for (int k = 0; k < 40; k++) begin
            if (done) break;
            lat++;
            @(negedge clk);
        end
        chk(lat == 11, "R10 latency unchanged", lat, 11);
        chk(result == e[15:0], "R10 result of first op", result, e[15:0]);
        @(negedge clk);
        chk(!done && !busy, "R10 no second operation", {done, busy}, 0);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_facts();
        t_zero_count();
        t_count_src();
        t_ignore_start();
        t_sweep();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule